// File: doc/BRIEF.md
# Multiplexed Scan Chain Test Sequencer

This block runs a structural test of a small piece of combinational logic through a chain of scan flip-flops. Each state flip-flop has a two-way input selector. With scan enable high, the flip-flops form one serial shift path. With it low, each flip-flop loads the next-state value from the logic under test. The logic under test sits outside the block and connects through ports. The flip-flop outputs (`scan_q`) and the primary-input pattern (`core_pi`) feed that logic. The logic returns its next-state bits (`core_d`) and its primary outputs (`core_po`).

A built-in sequencer takes the patterns in order from a computed table. For each pattern it shifts the starting state in serially, drives the primary inputs, and clocks the chain once with scan enable low. During that capture cycle it compares the primary outputs. It then shifts the captured state out while the next pattern's state shifts in. After the last pattern, one unload-only pass follows. Any mismatch sets a sticky fail flag and records the index of the first failing pattern. A done flag marks the end of the sequence. A start pulse begins the sequence again from the first pattern.

Top module: `scan_seq_top`

## Requirements
- R1: While the sequencer shifts (`scan_en`=1), cell 0 takes the serial input, cell i takes cell i-1, and `scan_out` is cell N-1. Each starting state is loaded most significant bit first, so after N shifts `scan_q` equals that state.
- R2: Pattern k (0-based) has starting state (5k+3) mod 2^N and primary inputs (7k+1) mod 2^N. Its expected primary outputs are state XOR inputs. Its expected captured state is (state + inputs) mod 2^N.
- R3: Each pattern gets exactly one chain-clocking cycle with `scan_en`=0, and in that cycle the chain loads `core_d`. `core_pi` carries pattern k's inputs only in that cycle and is 0 in every other cycle.
- R4: The N shifts after pattern k's capture unload k's response while loading pattern k+1's state. After the last pattern, one unload-only pass shifts in zeros.
- R5: `scan_out` is compared against the expected captured state on every unload shift. `core_po` is compared against the expected outputs in the capture cycle. A mismatch sets `fail` and records the failing pattern's index in `fail_pat`.
- R6: `fail` stays set until the next start, and `fail_pat` keeps the index of the first failing pattern.
- R7: `done` rises NUM_PAT*(N+1)+N clock edges after the edge that samples `start`. It then holds, the chain stays still, and `scan_q` is 0.
- R8: A `start` pulse in any state restarts the sequence at pattern 0 and clears `fail` and `fail_pat`.
- R9: After reset, `done`, `fail`, `scan_en`, `core_pi` and `scan_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin or restart the test sequence |
| scan_en | output | 1 | 1 = shift path, 0 = functional capture |
| scan_q | output | CHAIN_LEN | Flip-flop outputs to the logic under test |
| scan_out | output | 1 | Serial output, last cell of the chain |
| core_pi | output | CHAIN_LEN | Primary-input pattern to the logic under test |
| core_d | input | CHAIN_LEN | Next-state bits from the logic under test |
| core_po | input | CHAIN_LEN | Primary outputs from the logic under test |
| done | output | 1 | Sequence finished |
| fail | output | 1 | Sticky mismatch flag |
| fail_pat | output | $clog2(NUM_PAT) | Index of the first failing pattern |

## Verification
First, a fault-free model of the logic under test runs the full sequence. This checks the loaded states, the capture inputs, the cycle count and the zeroed chain at the end. Next, for every pattern index in turn, a bit flip is placed either in the next-state bits or in the primary outputs, only during that pattern's capture. The two kinds of fault are caught by different paths: serial compares during unload, and the compare in the capture cycle. Checking `fail_pat` against the index shows that each fault is credited to the right pattern. A run with two faults at different indices shows that only the first is kept. Runs that restart after a failure and restart partway through a sequence show that a restart clears the state.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_CAP   = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  // Starting state of pattern k (caller truncates to the chain width)
  function automatic int unsigned tp_state(int unsigned k);
    return 5 * k + 3;
  endfunction

  // Primary-input value of pattern k
  function automatic int unsigned tp_pi(int unsigned k);
    return 7 * k + 1;
  endfunction

  // Fault-free primary outputs of the logic under test
  function automatic int unsigned ref_po(int unsigned k);
    return tp_state(k) ^ tp_pi(k);
  endfunction

  // Fault-free captured next state of the logic under test
  function automatic int unsigned ref_next(int unsigned k);
    return tp_state(k) + tp_pi(k);
  endfunction

endpackage

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chain_en,
  input  logic         se,
  input  logic         si,
  input  logic [N-1:0] d,
  output logic [N-1:0] q,
  output logic         so
);

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic shift_src;
    if (i == 0) begin : g_head
      assign shift_src = si;
    end else begin : g_body
      assign shift_src = q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q[i] <= 1'b0;
      else if (chain_en) q[i] <= se ? shift_src : d[i];
    end
  end

  assign so = q[N-1];

  AST_SHIFT_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_en && se) |=> (q == {$past(q[N-2:0]), $past(si)})); // R1

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_en && !se) |=> (q == $past(d))); // R3

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_en |=> $stable(q)); // R7

endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int unsigned N       = 4,
  parameter int unsigned NUM_PAT = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       so,
  input  logic [N-1:0]               po,
  output logic                       chain_en,
  output logic                       se,
  output logic                       si,
  output logic [N-1:0]               pi,
  output logic                       done,
  output logic                       fail,
  output logic [$clog2(NUM_PAT)-1:0] fail_pat
);

  localparam int unsigned IDX_W = $clog2(NUM_PAT);
  localparam int unsigned PC_W  = $clog2(NUM_PAT + 1);
  localparam int unsigned BW    = (N > 1) ? $clog2(N) : 1;

  seq_state_e      state;
  logic [PC_W-1:0] pat;
  logic [BW-1:0]   bit_cnt;
  logic [BW-1:0]   bit_pos;
  logic [N-1:0]    load_vec, unl_vec, po_exp;
  logic [PC_W-1:0] prev_pat;
  logic            so_bad, po_bad;

  always_comb begin
    prev_pat = (pat == '0) ? '0 : pat - 1'b1;
    bit_pos  = BW'(N - 1) - bit_cnt;
    load_vec = N'(tp_state(32'(pat)));
    unl_vec  = N'(ref_next(32'(prev_pat)));
    po_exp   = N'(ref_po(32'(pat)));
    se       = (state == ST_SHIFT);
    chain_en = (state == ST_SHIFT) || (state == ST_CAP);
    si       = (state == ST_SHIFT) && (pat < PC_W'(NUM_PAT)) && load_vec[bit_pos];
    pi       = (state == ST_CAP) ? N'(tp_pi(32'(pat))) : '0;
    so_bad   = (state == ST_SHIFT) && (pat != '0) && (so != unl_vec[bit_pos]);
    po_bad   = (state == ST_CAP) && (po != po_exp);
    done     = (state == ST_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pat      <= '0;
      bit_cnt  <= '0;
      fail     <= 1'b0;
      fail_pat <= '0;
    end else if (start) begin
      state    <= ST_SHIFT;
      pat      <= '0;
      bit_cnt  <= '0;
      fail     <= 1'b0;
      fail_pat <= '0;
    end else begin
      case (state)
        ST_SHIFT: begin
          if (so_bad && !fail) begin
            fail     <= 1'b1;
            fail_pat <= IDX_W'(prev_pat);
          end
          if (bit_cnt == BW'(N - 1)) begin
            bit_cnt <= '0;
            state   <= (pat == PC_W'(NUM_PAT)) ? ST_DONE : ST_CAP;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_CAP: begin
          if (po_bad && !fail) begin
            fail     <= 1'b1;
            fail_pat <= IDX_W'(pat);
          end
          pat   <= pat + 1'b1;
          state <= ST_SHIFT;
        end
        default: ;
      endcase
    end
  end

  AST_CAPTURE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAP && !start) |=> (state == ST_SHIFT)); // R3

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> (fail && $stable(fail_pat))); // R6

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!fail && state == ST_SHIFT && pat == '0)); // R8

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R7

endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top #(
  parameter int unsigned CHAIN_LEN = 4,
  parameter int unsigned NUM_PAT   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  output logic                       scan_en,
  output logic [CHAIN_LEN-1:0]       scan_q,
  output logic                       scan_out,
  output logic [CHAIN_LEN-1:0]       core_pi,
  input  logic [CHAIN_LEN-1:0]       core_d,
  input  logic [CHAIN_LEN-1:0]       core_po,
  output logic                       done,
  output logic                       fail,
  output logic [$clog2(NUM_PAT)-1:0] fail_pat
);

  logic chain_en;
  logic scan_in;

  scan_chain #(.N(CHAIN_LEN)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .chain_en (chain_en),
    .se       (scan_en),
    .si       (scan_in),
    .d        (core_d),
    .q        (scan_q),
    .so       (scan_out)
  );

  scan_ctrl #(.N(CHAIN_LEN), .NUM_PAT(NUM_PAT)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .so       (scan_out),
    .po       (core_po),
    .chain_en (chain_en),
    .se       (scan_en),
    .si       (scan_in),
    .pi       (core_pi),
    .done     (done),
    .fail     (fail),
    .fail_pat (fail_pat)
  );

endmodule

// File: tb/scan_seq_top_test.sv
module scan_seq_top_test;

  localparam int N       = 4;
  localparam int P       = 8;
  localparam int CLK_T   = 10;
  localparam int IW      = $clog2(P);
  localparam int RUN_LEN = P * (N + 1) + N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          scan_en, scan_out, done, fail;
  logic [N-1:0]  scan_q, core_pi, core_d, core_po;
  logic [IW-1:0] fail_pat;

  int n_chk = 0;
  int n_bad = 0;

  // Fault injection: flip bits of next state / outputs during one pattern's capture
  int           fd_k = -1;
  int           fp_k = -1;
  logic [N-1:0] fd_mask = '0;
  logic [N-1:0] fp_mask = '0;

  always #(CLK_T / 2) clk = ~clk;

  function automatic logic [N-1:0] b_state(int k);
    return N'((5 * k + 3) % (1 << N));
  endfunction
  function automatic logic [N-1:0] b_pi(int k);
    return N'((7 * k + 1) % (1 << N));
  endfunction

  // Model of the logic under test (R2)
  always_comb begin
    core_d  = scan_q + core_pi;
    core_po = scan_q ^ core_pi;
    if (fd_k >= 0 && !scan_en && core_pi == b_pi(fd_k)) core_d  = core_d ^ fd_mask;
    if (fp_k >= 0 && !scan_en && core_pi == b_pi(fp_k)) core_po = core_po ^ fp_mask;
  end

  scan_seq_top #(.CHAIN_LEN(N), .NUM_PAT(P)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_en(scan_en), .scan_q(scan_q),
    .scan_out(scan_out), .core_pi(core_pi), .core_d(core_d), .core_po(core_po),
    .done(done), .fail(fail), .fail_pat(fail_pat)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Pulse start, then wait for done while watching each capture cycle
  task automatic run_seq(output int cyc, output int ncap, output int bad_cap,
                         output int bad_quiet);
    int k;
    cyc = 0; ncap = 0; bad_cap = 0; bad_quiet = 0; k = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      if (!done) begin
        if (!scan_en) begin
          if (scan_q != b_state(k) || core_pi != b_pi(k)) bad_cap++;
          k++;
          ncap++;
        end else if (core_pi != '0) begin
          bad_quiet++;
        end
      end
    end
  endtask

  initial begin
    #(CLK_T * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int cyc, ncap, bcap, bq;
    logic [N-1:0] q_hold;

    // R9: reset state
    @(negedge clk);
    check(!done && !fail && !scan_en && core_pi == 0 && scan_q == 0, "R9",
          {done, fail, scan_en}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Fault-free run: R1 R2 R3 R4 R7
    run_seq(cyc, ncap, bcap, bq);
    check(cyc == RUN_LEN, "R7 cycles", cyc, RUN_LEN);
    check(ncap == P, "R3 captures", ncap, P);
    check(bcap == 0, "R1 loaded state", bcap, 0);
    check(bq == 0, "R3 inputs quiet", bq, 0);
    check(!fail, "R5 clean run", fail, 0);
    check(scan_q == 0, "R4 zero fill", scan_q, 0);
    q_hold = scan_q;
    repeat (5) @(negedge clk);
    check(done && scan_q == q_hold, "R7 hold", scan_q, q_hold);

    // Next-state faults at every pattern index: caught on unload (R4 R5)
    for (int k = 0; k < P; k++) begin
      fd_k = k; fd_mask = N'(1 << (k % N));
      run_seq(cyc, ncap, bcap, bq);
      check(fail, "R4 unload fault", fail, 1);
      check(fail_pat == IW'(k), "R5 index", fail_pat, k);
    end
    fd_k = -1;

    // Output faults at every pattern index: caught in capture (R5)
    for (int k = 0; k < P; k++) begin
      fp_k = k; fp_mask = N'(1 << ((k + 1) % N));
      run_seq(cyc, ncap, bcap, bq);
      check(fail && fail_pat == IW'(k), "R5 output fault", fail_pat, k);
    end
    fp_k = -1;

    // R6: first failure kept
    fd_k = 1; fd_mask = 4'b0100; fp_k = 6; fp_mask = 4'b0001;
    run_seq(cyc, ncap, bcap, bq);
    check(fail && fail_pat == 1, "R6 first kept", fail_pat, 1);
    fd_k = 6; fp_k = 1;
    run_seq(cyc, ncap, bcap, bq);
    check(fail && fail_pat == 1, "R6 first kept", fail_pat, 1);
    fd_k = -1; fp_k = -1;

    // R8: restart after failure clears flags
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!fail && fail_pat == 0 && !done, "R8 clear", fail, 0);
    repeat (12) @(negedge clk);

    // R8: restart partway through a run
    run_seq(cyc, ncap, bcap, bq);
    check(cyc == RUN_LEN && ncap == P && bcap == 0 && !fail, "R8 restart", cyc, RUN_LEN);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule